// File: doc/BRIEF.md
# Two-Read One-Write Register File with Same-Cycle Write Forwarding

This block holds the general-purpose registers that a pipelined core reads in its decode stage. It has two independent read ports and one write port. The read data is combinational from the read address. The write port is sampled on the rising clock edge. Register 0 is hard-wired to zero.

The writeback stage may write a register in the same cycle that decode reads it. In that case the read port returns the data being written, not the old stored value. This gives the same result as a file that writes in the first half of the cycle and reads in the second half. A single-edge clock can therefore remove the writeback-to-decode data hazard. The data width and the register count are parameters. Each read port makes its own forwarding decision.

Top module: `regfile_bypass`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. This holds even if a write is requested in the same cycle.
- R2: A rising edge with wr_en=1 and a nonzero wr_addr stores wr_data in that register. Later reads of that address return it until it is written again.
- R3: A rising edge with wr_en=0 changes no register.
- R4: Address 0 always reads as zero on both ports. A write to address 0 leaves every register unchanged.
- R5: The same-cycle bypass applies when wr_en=1, wr_addr is nonzero and a read address equals wr_addr. The read port then returns wr_data in that same cycle, before the edge.
- R6: No bypass occurs when wr_en=0 or when wr_addr=0. In those cases a read returns the stored value, and a read of address 0 returns zero.
- R7: The two read ports bypass independently. Both ports return wr_data when both match, and a non-matching port returns its stored value.
- R8: During a write, a read of a different address returns that register's stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr_a | input | $clog2(NUM_REGS) | Read address, port A |
| rd_data_a | output | DATA_W | Read data, port A (combinational) |
| rd_addr_b | input | $clog2(NUM_REGS) | Read address, port B |
| rd_data_b | output | DATA_W | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | $clog2(NUM_REGS) | Write address |
| wr_data | input | DATA_W | Write data |

## Verification
The main function is tried with four kinds of read/write pattern:
- A read that matches an enabled write to a nonzero register. This separates correct forwarding from returning stale stored data.
- Writes that are disabled, or that target register 0. These tell a correct forwarding qualifier from one that ignores the enable or the zero address.
- Reads where both ports match, and reads where only one port matches. These show that each port decides on its own.
- A model-driven sweep that writes every register and then reads every pair. This catches address decode errors, such as a write landing in the wrong register.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int RF_RD_PORTS = 2;

  function automatic bit rf_fwd_hit(input bit we, input int unsigned waddr,
                                     input int unsigned raddr);
    return we && (waddr != 0) && (waddr == raddr);
  endfunction
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int NUM_REGS = 8,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_REGS-1:1] wr_sel
);
  genvar gi;
  generate
    for (gi = 1; gi < NUM_REGS; gi++) begin : g_sel
      assign wr_sel[gi] = wr_en && (wr_addr == ADDR_W'(gi));
    end
  endgenerate
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_REGS-1:1]              wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
  assign regs_q[0] = '0;

  genvar gi;
  generate
    for (gi = 1; gi < NUM_REGS; gi++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          regs_q[gi] <= '0;
        end else if (wr_sel[gi]) begin
          regs_q[gi] <= wr_data;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q,
  input  logic [ADDR_W-1:0]               rd_addr,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [DATA_W-1:0]               rd_data
);
  logic fwd_hit;

  always_comb begin
    fwd_hit = rf_pkg::rf_fwd_hit(wr_en, int'(wr_addr), int'(rd_addr));
    if (fwd_hit) begin
      rd_data = wr_data;
    end else begin
      rd_data = regs_q[rd_addr];
    end
  end
endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int NRD = rf_pkg::RF_RD_PORTS;

  logic [NUM_REGS-1:1]             wr_sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NRD-1:0][ADDR_W-1:0]      raddr;
  logic [NRD-1:0][DATA_W-1:0]      rdata;

  assign raddr[0]  = rd_addr_a;
  assign raddr[1]  = rd_addr_b;
  assign rd_data_a = rdata[0];
  assign rd_data_b = rdata[1];

  rf_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_sel (wr_sel)
  );

  rf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .regs_q (regs_q)
  );

  genvar gp;
  generate
    for (gp = 0; gp < NRD; gp++) begin : g_rd
      rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd (
        .regs_q (regs_q),
        .rd_addr(raddr[gp]),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_data(rdata[gp])
      );
    end
  endgenerate
endmodule

// File: rtl/rf_bypass_chk.sv
module rf_bypass_chk #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [DATA_W-1:0] rd_data_b,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !wr_en) |-> (rd_data_a == '0 && rd_data_b == '0)); // R1

  AST_WRITE_STICKS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0) |=>
      (rd_addr_a != $past(wr_addr) || (wr_en && wr_addr == rd_addr_a) ||
       rd_data_a == $past(wr_data))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_en ##1 (!wr_en && $stable(rd_addr_a))) |-> $stable(rd_data_a)); // R3

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |-> (rd_data_a == '0)); // R4

  AST_FWD_PORT_A: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && rd_addr_a == wr_addr) |-> (rd_data_a == wr_data)); // R5

  AST_FWD_PORT_B: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && rd_addr_b == wr_addr) |-> (rd_data_b == wr_data)); // R7
endmodule

bind regfile_bypass rf_bypass_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst),
  .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
  .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/sim_regfile_bypass.sv
`timescale 1ns/1ps
module sim_regfile_bypass;
  localparam int DW = 32;
  localparam int NR = 8;
  localparam int AW = $clog2(NR);

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] rd_addr_a, rd_addr_b, wr_addr;
  logic [DW-1:0] rd_data_a, rd_data_b, wr_data;
  logic wr_en;

  int n_run = 0;
  int n_fail = 0;
  logic [DW-1:0] model [NR];

  always #2.5 clk = ~clk;

  regfile_bypass #(.DATA_W(DW), .NUM_REGS(NR)) u0 (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  typedef struct packed {
    logic          we;
    logic [2:0]    wa;
    logic [31:0]   wd;
    logic [2:0]    ra;
    logic [2:0]    rb;
    logic [31:0]   ea;
    logic [31:0]   eb;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd3, 32'hA3, 3'd3, 3'd1, 32'hA3, 32'h0,  8'd5}, // R5 forward on A
    '{1'b1, 3'd5, 32'hB5, 3'd3, 3'd5, 32'hA3, 32'hB5, 8'd8}, // R8 other address stored
    '{1'b0, 3'd3, 32'hFF, 3'd3, 3'd5, 32'hA3, 32'hB5, 8'd6}, // R6 no forward when disabled
    '{1'b1, 3'd0, 32'hDE, 3'd0, 3'd0, 32'h0,  32'h0,  8'd6}, // R6 no forward to address 0
    '{1'b0, 3'd0, 32'h0,  3'd0, 3'd3, 32'h0,  32'hA3, 8'd4}, // R4 zero write ignored
    '{1'b1, 3'd7, 32'hC7, 3'd7, 3'd7, 32'hC7, 32'hC7, 8'd7}, // R7 both ports forward
    '{1'b1, 3'd3, 32'hD3, 3'd3, 3'd7, 32'hD3, 32'hC7, 8'd7}, // R7 one port only
    '{1'b1, 3'd1, 32'hE1, 3'd2, 3'd1, 32'h0,  32'hE1, 8'd5},
    '{1'b0, 3'd1, 32'h0,  3'd1, 3'd3, 32'hE1, 32'hD3, 8'd2}, // R2 stored values
    '{1'b1, 3'd5, 32'hF5, 3'd5, 3'd6, 32'hF5, 32'h0,  8'd5},
    '{1'b0, 3'd5, 32'h0,  3'd5, 3'd7, 32'hF5, 32'hC7, 8'd3}  // R3 idle write
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input logic [AW-1:0] ra, input logic [AW-1:0] rb);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
    #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr_a = '0; rd_addr_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NR; i += 2) begin
      drive(1'b0, '0, '0, AW'(i), AW'(i + 1));
      check($sformatf("R1 reset reg %0d", i), rd_data_a, '0);
      check($sformatf("R1 reset reg %0d", i + 1), rd_data_b, '0);
    end

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v].we, VEC[v].wa, VEC[v].wd, VEC[v].ra, VEC[v].rb);
      check($sformatf("R%0d vec %0d port A", VEC[v].req, v), rd_data_a, VEC[v].ea);
      check($sformatf("R%0d vec %0d port B", VEC[v].req, v), rd_data_b, VEC[v].eb);
    end

    // R1: reset wins over a simultaneous write, and clears earlier contents
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h44;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    for (int i = 0; i < NR; i++) begin
      drive(1'b0, '0, '0, AW'(i), 3'd4);
      check($sformatf("R1 after reset reg %0d", i), rd_data_a, '0);
    end

    // R2 model sweep: write each register, compare every pair with the model
    for (int i = 0; i < NR; i++) begin
      logic [DW-1:0] pat;
      pat = 32'h1000_0000 + DW'(i) * 32'h0101_0101 + 32'h5;
      drive(1'b1, AW'(i), pat, AW'(i), '0);
      check($sformatf("R5 sweep forward reg %0d", i), rd_data_a, (i == 0) ? '0 : pat);
      if (i != 0) model[i] = pat;
    end
    for (int i = 0; i < NR; i++) begin
      for (int j = 0; j < NR; j++) begin
        drive(1'b0, AW'(j), 32'hBAD0_0000, AW'(i), AW'(j));
        check($sformatf("R2 sweep A reg %0d", i), rd_data_a, model[i]);
        check($sformatf("R2 sweep B reg %0d", j), rd_data_b, model[j]);
      end
    end

    // R4: write to zero with all-ones then read back, zero everywhere else unchanged
    drive(1'b1, '0, '1, 3'd0, 3'd2);
    check("R4 zero during write", rd_data_a, '0);
    check("R8 other reg during zero write", rd_data_b, model[2]);
    drive(1'b0, '0, '0, 3'd0, 3'd2);
    check("R4 zero after write", rd_data_a, '0);
    check("R4 reg2 untouched", rd_data_b, model[2]);

    drive(1'b0, '0, '0, '0, '0);
    finish_run();
  end
endmodule